// File: doc/BRIEF.md
# Bit-Serial Register Transfer Unit

This block moves the contents of one register into another over a single wire. Two shift registers of equal width, a sender and a receiver, both shift toward their least significant end. The bit that leaves the sender at its LSB enters the receiver at its MSB. After as many shifts as the register is wide, the receiver holds the sender's former word. The bits the receiver held before leave through its serial output and are dropped.

A fill-mode input decides what enters the sender's MSB. In zero-fill mode a zero enters, so a full-width transfer empties the sender. In recirculate mode the sender's own outgoing LSB enters, so the sender rotates and holds its original word after a full-width transfer.

Shifting is a synchronous enable that is sampled on each clock edge, so the number of enabled edges sets how far the data moves. A parallel load sets both registers at once and wins over shifting. A start strobe captures a shift count. A one-cycle done pulse then marks the moment that many shifts have been taken.

Top module: `serial_xfer_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both registers clear to 0 and `done` is 0 after that edge.
- R2: On an edge where `load` is 1, the sender takes `snd_init` and the receiver takes `rcv_init`. This holds even when `shift` is also 1.
- R3: On an edge where `shift` is 0 and `load` is 0, both registers keep their values.
- R4: On an edge where `shift` is 1 and `load` is 0, the receiver shifts right and its MSB takes the sender's previous bit 0. `rcv_so` always shows the receiver's bit 0, so the old receiver bits leave LSB first.
- R5: With `fill_mode` = 0 (zero-fill), each shift puts 0 into the sender's MSB. After WIDTH shifts the sender is 0 and the receiver holds the sender's old word.
- R6: With `fill_mode` = 1 (recirculate), each shift puts the sender's previous bit 0 into its MSB. After WIDTH shifts the sender equals its old word and the receiver holds a copy of it.
- R7: On an edge where `start` is 1, the count on `shift_count` (N > 0) is captured. Shifts taken on later edges are counted. `done` is 1 for exactly one cycle, right after the edge of the Nth counted shift. Cycles with `shift` low are not counted.
- R8: A `start` with `shift_count` = 0 makes `done` 1 for one cycle right after the start edge.
- R9: An edge where `load` and `shift` are both 1 is not counted as a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel load of both registers |
| snd_init | input | WIDTH | Load value for the sender |
| rcv_init | input | WIDTH | Load value for the receiver |
| fill_mode | input | 1 | 0 = zero-fill, 1 = recirculate |
| shift | input | 1 | Shift enable for both registers |
| start | input | 1 | Capture `shift_count` and arm the counter |
| shift_count | input | CNT_W | Number of shifts until `done` |
| snd_q | output | WIDTH | Sender register contents |
| rcv_q | output | WIDTH | Receiver register contents |
| rcv_so | output | 1 | Receiver serial output (its bit 0) |
| done | output | 1 | One-cycle pulse after the counted shifts |

## Verification
Parallel load and shifting can be requested on the same edge. The bench raises `load` and `shift` together with fresh load values. It then checks that both registers show exactly the loaded words, with no shifted bits. The same collision is raised while a count is armed. The bench then checks that `done` arrives only after the full number of later shift-only cycles, which shows that the colliding edge was not counted.

// File: rtl/serial_xfer_pkg.sv
package serial_xfer_pkg;
  typedef enum logic {
    FILL_ZERO  = 1'b0,
    FILL_RECIR = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/xfer_shift_reg.sv
module xfer_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  input  logic             si,
  output logic [WIDTH-1:0] q,
  output logic             so
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= din;
    else if (en)  q <= {si, q[WIDTH-1:1]};
  end

  assign so = q[0];

  // R2: load wins and installs the parallel value
  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(din));
  // R3: no enable, no load -> hold
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en) |=> $stable(q));
  // R4: right shift moves upper bits down by one
  a_r4_shift_body: assert property (@(posedge clk) disable iff (rst)
    (en && !ld) |=> q[WIDTH-2:0] == $past(q[WIDTH-1:1]));
endmodule

// File: rtl/xfer_fill_sel.sv
module xfer_fill_sel
  import serial_xfer_pkg::*;
(
  input  fill_mode_e mode,
  input  logic       snd_so,
  output logic       snd_si
);
  always_comb begin
    unique case (mode)
      FILL_RECIR: snd_si = snd_so;
      default:    snd_si = 1'b0;
    endcase
  end
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] count_in,
  input  logic             tick,
  output logic             done
);
  logic [CNT_W-1:0] remain;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      armed  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remain <= count_in;
        armed  <= (count_in != '0);
        done   <= (count_in == '0);
      end else if (armed && tick) begin
        remain <= remain - 1'b1;
        if (remain == {{(CNT_W-1){1'b0}}, 1'b1}) begin
          armed <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  // R7: a done pulse always follows a start or a counted shift
  a_r7_done_cause: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start || (armed && tick)));
  // R7: last counted shift raises done
  a_r7_last_tick: assert property (@(posedge clk) disable iff (rst)
    (!start && armed && tick && remain == {{(CNT_W-1){1'b0}}, 1'b1}) |=> done);
  // R8: zero count completes at once
  a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
    (start && count_in == '0) |=> done);
endmodule

// File: rtl/serial_xfer_unit.sv
module serial_xfer_unit
  import serial_xfer_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter int MAX_COUNT = 15,
  localparam int CNT_W    = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] snd_init,
  input  logic [WIDTH-1:0] rcv_init,
  input  logic             fill_mode,
  input  logic             shift,
  input  logic             start,
  input  logic [CNT_W-1:0] shift_count,
  output logic [WIDTH-1:0] snd_q,
  output logic [WIDTH-1:0] rcv_q,
  output logic             rcv_so,
  output logic             done
);
  logic       snd_so;
  logic       snd_si;
  logic       shift_ok;
  fill_mode_e mode;

  assign mode     = fill_mode_e'(fill_mode);
  assign shift_ok = shift & ~load;

  xfer_fill_sel u_fill (
    .mode   (mode),
    .snd_so (snd_so),
    .snd_si (snd_si)
  );

  xfer_shift_reg #(.WIDTH(WIDTH)) u_sender (
    .clk (clk), .rst (rst), .ld (load), .en (shift),
    .din (snd_init), .si (snd_si), .q (snd_q), .so (snd_so)
  );

  xfer_shift_reg #(.WIDTH(WIDTH)) u_receiver (
    .clk (clk), .rst (rst), .ld (load), .en (shift),
    .din (rcv_init), .si (snd_so), .q (rcv_q), .so (rcv_so)
  );

  xfer_counter #(.CNT_W(CNT_W)) u_count (
    .clk (clk), .rst (rst), .start (start), .count_in (shift_count),
    .tick (shift_ok), .done (done)
  );

  // R4: receiver MSB takes the sender's outgoing bit
  a_r4_link: assert property (@(posedge clk) disable iff (rst)
    shift_ok |=> rcv_q[WIDTH-1] == $past(snd_q[0]));
  // R5: zero-fill enters a 0 at the sender MSB
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (shift_ok && !fill_mode) |=> snd_q[WIDTH-1] == 1'b0);
  // R6: recirculation feeds bit 0 back to the MSB
  a_r6_recirculate: assert property (@(posedge clk) disable iff (rst)
    (shift_ok && fill_mode) |=> snd_q[WIDTH-1] == $past(snd_q[0]));
  // R1: after reset the pulse is idle
  a_r1_reset_done: assert property (@(posedge clk)
    $past(rst) |-> !done);
endmodule

// File: tb/test_serial_xfer_unit.sv
module test_serial_xfer_unit;
  localparam int W  = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst, load, fill_mode, shift, start;
  logic [W-1:0]  snd_init, rcv_init;
  logic [CW-1:0] shift_count;
  logic [W-1:0]  snd_q, rcv_q;
  logic          rcv_so, done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  serial_xfer_unit #(.WIDTH(W), .MAX_COUNT(15)) i_serial_xfer_unit (
    .clk, .rst, .load, .snd_init, .rcv_init, .fill_mode, .shift,
    .start, .shift_count, .snd_q, .rcv_q, .rcv_so, .done
  );

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    load = 0; shift = 0; start = 0;
  endtask

  task automatic do_load(logic [W-1:0] s, logic [W-1:0] r);
    idle(); load = 1; snd_init = s; rcv_init = r;
    cyc(); idle();
  endtask

  task automatic t_reset();
    rst = 1; idle(); fill_mode = 0; snd_init = '1; rcv_init = '1; shift_count = '0;
    cyc(); cyc();
    chk("R1 snd", snd_q, 0);
    chk("R1 rcv", rcv_q, 0);
    chk("R1 done", done, 0);
    rst = 0; cyc();
  endtask

  task automatic t_load_priority();
    do_load(4'hA, 4'h5);
    chk("R2 snd", snd_q, 4'hA);
    chk("R2 rcv", rcv_q, 4'h5);
    load = 1; shift = 1; snd_init = 4'h3; rcv_init = 4'hC;
    cyc(); idle();
    chk("R2 collide snd", snd_q, 4'h3);
    chk("R2 collide rcv", rcv_q, 4'hC);
  endtask

  task automatic t_hold();
    do_load(4'h9, 4'h6);
    for (int i = 0; i < 3; i++) cyc();
    chk("R3 snd", snd_q, 4'h9);
    chk("R3 rcv", rcv_q, 4'h6);
  endtask

  task automatic t_transfer(logic md, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] ms, mr;
    do_load(a, b);
    fill_mode = md; ms = a; mr = b;
    for (int i = 0; i < W; i++) begin
      chk("R4 rcv_so", rcv_so, mr[0]);
      shift = 1; cyc(); shift = 0;
      mr = {ms[0], mr[W-1:1]};
      ms = {md ? ms[0] : 1'b0, ms[W-1:1]};
      chk("R4 rcv step", rcv_q, mr);
      chk(md ? "R6 snd step" : "R5 snd step", snd_q, ms);
    end
    chk(md ? "R6 snd final" : "R5 snd final", snd_q, md ? a : 0);
    chk(md ? "R6 rcv final" : "R5 rcv final", rcv_q, a);
  endtask

  task automatic t_done_count();
    idle(); start = 1; shift_count = 3; cyc(); idle();
    chk("R7 after start", done, 0);
    shift = 1; cyc(); shift = 0;
    cyc();
    chk("R7 gap", done, 0);
    shift = 1; cyc();
    chk("R7 second", done, 0);
    cyc();
    chk("R7 third", done, 1);
    cyc();
    chk("R7 one cycle", done, 0);
    cyc(); shift = 0;
    chk("R7 disarmed", done, 0);
  endtask

  task automatic t_done_zero();
    idle(); start = 1; shift_count = 0; cyc(); idle();
    chk("R8 zero", done, 1);
    cyc();
    chk("R8 clear", done, 0);
  endtask

  task automatic t_load_no_count();
    idle(); start = 1; shift_count = 2; cyc(); idle();
    load = 1; shift = 1; snd_init = 4'h1; rcv_init = 4'h2; cyc(); idle();
    chk("R9 collide", done, 0);
    shift = 1; cyc();
    chk("R9 first", done, 0);
    cyc(); shift = 0;
    chk("R9 second", done, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load_priority();
        t_hold();
        t_transfer(1'b0, 4'hB, 4'h4);
        t_transfer(1'b1, 4'hD, 4'h2);
        t_transfer(1'b0, 4'h8, 4'h5);
        t_done_count();
        t_done_zero();
        t_load_no_count();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule